// File: doc/BRIEF.md
# Periodic Core Restart Timer

This block governs when a small always-on core is started again. Software launches the core once with a start address. From then on, each time the core reports that it has halted, the block loads the currently chosen sleep interval and counts clock cycles. When the count reaches that interval, it issues a one-cycle restart pulse, and the core begins again from the stored start address. A halt therefore parks the core for a while rather than stopping the system for good.

Five interval values are supplied on a flat input bus. A select strobe chooses which of the five applies, and the choice takes effect at the next halt. The core can issue an end command, which clears the timer enable. The program that is running finishes, but no further restart follows until software launches the core again. The core can also issue a wake command, which produces a one-cycle wake-up pulse towards the rest of the chip. A wake command does not interrupt the program or the periodic schedule.

Top module: `rearm_timer`

## Requirements
- R1: After synchronous reset, restart_o, wake_o, timer_en_o and running_o are 0, and the interval select is 0. A halt received while the core is not running has no effect.
- R2: One cycle after launch_i, restart_o pulses for one cycle. In the same cycle start_addr_o shows the captured launch_addr_i, timer_en_o is 1 and running_o is 1.
- R3: When core_halt_i is sampled high while running with the timer enabled, running_o drops. restart_o pulses exactly P+1 cycles after the halt cycle, where P is the selected interval. P = 0 gives a restart on the next cycle.
- R4: A select write with sel_i in 0..4 chooses interval slot sel_i, the slot at bits [PERIOD_W*k +: PERIOD_W] of period_flat_i. A write with sel_i of 5 or more is ignored and the previous choice stays in force.
- R5: A select write made while counting does not change the wait in progress. It applies from the next halt.
- R6: end_cmd_i clears timer_en_o one cycle later and leaves running_o unchanged. With the timer disabled, a later halt moves the core to idle and no restart pulse follows. An end command arriving while counting cancels the pending restart.
- R7: A launch after an end command sets timer_en_o to 1 again, and periodic restarts resume.
- R8: wake_cmd_i produces wake_o high for exactly the following cycle. running_o and timer_en_o are unaffected, and the next halt still restarts on schedule.
- R9: A periodic restart keeps start_addr_o at the address captured by the last launch.
- R10: When launch_i and end_cmd_i occur in the same cycle, the launch wins and timer_en_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_i | input | 1 | Software start strobe |
| launch_addr_i | input | ADDR_W | Start address captured on launch |
| core_halt_i | input | 1 | Core reports halt (one-cycle strobe) |
| period_flat_i | input | NUM_PERIODS*PERIOD_W | Five interval values, slot k at [PERIOD_W*k +: PERIOD_W] |
| sel_we_i | input | 1 | Interval select write strobe |
| sel_i | input | SEL_W | Interval slot index for the select write |
| end_cmd_i | input | 1 | Core command: disable the restart timer |
| wake_cmd_i | input | 1 | Core command: request chip wake-up |
| restart_o | output | 1 | One-cycle restart pulse to the core |
| start_addr_o | output | ADDR_W | Address the core starts from |
| running_o | output | 1 | Core considered running |
| timer_en_o | output | 1 | Periodic restart timer enabled |
| wake_o | output | 1 | One-cycle wake-up pulse |

## Verification
A wrong interval capture, or a counter that was not cleared, shows up as a restart pulse arriving early or late against the P+1 cycle spacing. This is visible within one interval of the halt. A wrong select register shows up at the next halt as the delay of a different slot, and the table sweeps every slot, including out-of-range indices. A stale enable shows up either as a restart after an end command, which the bench watches for over a long window, or as a missing restart after a relaunch.

// File: rtl/rearm_pkg.sv
package rearm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_WAIT = 2'd2
  } phase_t;
endpackage

// File: rtl/rearm_period_sel.sv
module rearm_period_sel #(
  parameter int NUM_PERIODS = 5,
  parameter int PERIOD_W    = 16,
  localparam int SEL_W      = (NUM_PERIODS > 1) ? $clog2(NUM_PERIODS) : 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            sel_we_i,
  input  logic [SEL_W-1:0]                sel_i,
  input  logic [NUM_PERIODS*PERIOD_W-1:0] period_flat_i,
  output logic [PERIOD_W-1:0]             period_o
);
  logic [PERIOD_W-1:0] slot [NUM_PERIODS];
  logic [SEL_W-1:0]    sel_q;

  for (genvar k = 0; k < NUM_PERIODS; k++) begin : g_slot
    assign slot[k] = period_flat_i[PERIOD_W*k +: PERIOD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (sel_we_i && (sel_i < SEL_W'(NUM_PERIODS))) begin
      sel_q <= sel_i;
    end
  end

  assign period_o = slot[sel_q];

  AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    sel_q < SEL_W'(NUM_PERIODS)); // R4

  AST_SEL_BAD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (sel_we_i && (sel_i >= SEL_W'(NUM_PERIODS))) |=> $stable(sel_q)); // R4
endmodule

// File: rtl/rearm_counter.sv
module rearm_counter #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_i,
  input  logic                inc_i,
  output logic [PERIOD_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_o <= '0;
    end else if (inc_i) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/rearm_seq.sv
module rearm_seq
  import rearm_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int ADDR_W   = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                launch_i,
  input  logic [ADDR_W-1:0]   launch_addr_i,
  input  logic                core_halt_i,
  input  logic                end_cmd_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [PERIOD_W-1:0] cnt_i,
  output logic                cnt_clr_o,
  output logic                cnt_inc_o,
  output logic                restart_o,
  output logic [ADDR_W-1:0]   start_addr_o,
  output logic                running_o,
  output logic                timer_en_o
);
  phase_t              phase_q;
  logic [PERIOD_W-1:0] target_q;
  logic                en_next;
  logic                hit;

  assign en_next   = timer_en_o & ~end_cmd_i;
  assign hit       = (cnt_i == target_q);
  assign cnt_clr_o = (phase_q != PH_WAIT) | hit | launch_i | ~en_next;
  assign cnt_inc_o = (phase_q == PH_WAIT) & ~hit;
  assign running_o = (phase_q == PH_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q      <= PH_IDLE;
      timer_en_o   <= 1'b0;
      restart_o    <= 1'b0;
      start_addr_o <= '0;
      target_q     <= '0;
    end else begin
      restart_o <= 1'b0;
      if (end_cmd_i) timer_en_o <= 1'b0;
      if (launch_i) begin
        timer_en_o   <= 1'b1;
        start_addr_o <= launch_addr_i;
        restart_o    <= 1'b1;
        phase_q      <= PH_RUN;
      end else begin
        unique case (phase_q)
          PH_RUN: begin
            if (core_halt_i) begin
              target_q <= period_i;
              phase_q  <= en_next ? PH_WAIT : PH_IDLE;
            end
          end
          PH_WAIT: begin
            if (!en_next) begin
              phase_q <= PH_IDLE;
            end else if (hit) begin
              restart_o <= 1'b1;
              phase_q   <= PH_RUN;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_LAUNCH_STARTS: assert property (@(posedge clk) disable iff (rst)
    launch_i |=> (restart_o && timer_en_o && running_o)); // R2

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_WAIT) |-> (cnt_i <= target_q)); // R3

  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_WAIT) |-> (cnt_i == '0)); // R3

  AST_END_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (end_cmd_i && !launch_i) |=> !timer_en_o); // R6

  AST_NO_RESTART_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!timer_en_o && !launch_i) |=> !restart_o); // R6

  AST_ADDR_KEPT: assert property (@(posedge clk) disable iff (rst)
    !launch_i |=> $stable(start_addr_o)); // R9
endmodule

// File: rtl/rearm_timer.sv
module rearm_timer #(
  parameter int NUM_PERIODS = 5,
  parameter int PERIOD_W    = 16,
  parameter int ADDR_W      = 11,
  localparam int SEL_W      = (NUM_PERIODS > 1) ? $clog2(NUM_PERIODS) : 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            launch_i,
  input  logic [ADDR_W-1:0]               launch_addr_i,
  input  logic                            core_halt_i,
  input  logic [NUM_PERIODS*PERIOD_W-1:0] period_flat_i,
  input  logic                            sel_we_i,
  input  logic [SEL_W-1:0]                sel_i,
  input  logic                            end_cmd_i,
  input  logic                            wake_cmd_i,
  output logic                            restart_o,
  output logic [ADDR_W-1:0]               start_addr_o,
  output logic                            running_o,
  output logic                            timer_en_o,
  output logic                            wake_o
);
  logic [PERIOD_W-1:0] period_sel;
  logic [PERIOD_W-1:0] cnt;
  logic                cnt_clr;
  logic                cnt_inc;

  rearm_period_sel #(.NUM_PERIODS(NUM_PERIODS), .PERIOD_W(PERIOD_W)) u_sel (
    .clk(clk), .rst(rst), .sel_we_i(sel_we_i), .sel_i(sel_i),
    .period_flat_i(period_flat_i), .period_o(period_sel)
  );

  rearm_counter #(.PERIOD_W(PERIOD_W)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(cnt_clr), .inc_i(cnt_inc), .cnt_o(cnt)
  );

  rearm_seq #(.PERIOD_W(PERIOD_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .launch_i(launch_i), .launch_addr_i(launch_addr_i),
    .core_halt_i(core_halt_i), .end_cmd_i(end_cmd_i), .period_i(period_sel),
    .cnt_i(cnt), .cnt_clr_o(cnt_clr), .cnt_inc_o(cnt_inc),
    .restart_o(restart_o), .start_addr_o(start_addr_o),
    .running_o(running_o), .timer_en_o(timer_en_o)
  );

  always_ff @(posedge clk) begin
    if (rst) wake_o <= 1'b0;
    else     wake_o <= wake_cmd_i;
  end

  AST_WAKE_KEEPS_RUN: assert property (@(posedge clk) disable iff (rst)
    (wake_cmd_i && running_o && !core_halt_i && !launch_i) |=> running_o); // R8

  AST_WAKE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (!wake_cmd_i) |=> !wake_o); // R8
endmodule

// File: tb/tb_rearm_timer.sv
module tb_rearm_timer;
  localparam int NP = 5;
  localparam int PW = 16;
  localparam int AW = 11;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic launch_i = 1'b0;
  logic [AW-1:0] launch_addr_i = '0;
  logic core_halt_i = 1'b0;
  logic [NP*PW-1:0] period_flat_i;
  logic sel_we_i = 1'b0;
  logic [SW-1:0] sel_i = '0;
  logic end_cmd_i = 1'b0;
  logic wake_cmd_i = 1'b0;
  logic restart_o, running_o, timer_en_o, wake_o;
  logic [AW-1:0] start_addr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  // interval slots: 3, 0, 7, 12, 1
  assign period_flat_i = {16'd1, 16'd12, 16'd7, 16'd0, 16'd3};

  rearm_timer dut (
    .clk(clk), .rst(rst), .launch_i(launch_i), .launch_addr_i(launch_addr_i),
    .core_halt_i(core_halt_i), .period_flat_i(period_flat_i),
    .sel_we_i(sel_we_i), .sel_i(sel_i), .end_cmd_i(end_cmd_i),
    .wake_cmd_i(wake_cmd_i), .restart_o(restart_o), .start_addr_o(start_addr_o),
    .running_o(running_o), .timer_en_o(timer_en_o), .wake_o(wake_o)
  );

  // {select index, expected halt-to-restart delay}; indices 5 and 7 are out of range
  localparam logic [10:0] VEC [10] = '{
    {3'd0, 8'd4}, {3'd1, 8'd1}, {3'd2, 8'd8}, {3'd3, 8'd13}, {3'd4, 8'd2},
    {3'd5, 8'd2}, {3'd7, 8'd2}, {3'd2, 8'd8}, {3'd1, 8'd1}, {3'd0, 8'd4}
  };

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_launch(input logic [AW-1:0] a);
    launch_i = 1'b1; launch_addr_i = a;
    tick;
    launch_i = 1'b0;
  endtask

  task automatic write_sel(input logic [SW-1:0] s);
    sel_we_i = 1'b1; sel_i = s;
    tick;
    sel_we_i = 1'b0;
  endtask

  // halt the core and return cycles until restart_o is seen (200 = none)
  task automatic halt_delay(output int n);
    core_halt_i = 1'b1;
    tick;
    core_halt_i = 1'b0;
    n = 0;
    while (!restart_o && n < 200) begin
      tick;
      n++;
    end
  endtask

  task automatic quiet_window(input int len, input string tag);
    int seen = 0;
    for (int i = 0; i < len; i++) begin
      tick;
      if (restart_o) seen++;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  initial begin
    int d;
    repeat (3) tick;
    rst = 1'b0;
    // R1 reset state
    chk(!restart_o && !wake_o && !timer_en_o && !running_o, "R1 reset outputs",
        {restart_o, wake_o, timer_en_o, running_o}, 0);
    core_halt_i = 1'b1; tick; core_halt_i = 1'b0;
    quiet_window(10, "R1 halt while idle ignored");
    chk(!running_o, "R1 still idle", running_o, 0);

    // R2 launch
    do_launch(11'h155);
    chk(restart_o && timer_en_o && running_o, "R2 launch pulse/enable/run",
        {restart_o, timer_en_o, running_o}, 7);
    chk(start_addr_o == 11'h155, "R2 start address", start_addr_o, 'h155);
    tick;
    chk(!restart_o, "R2 pulse one cycle", restart_o, 0);

    // R3 R4 table: default select 0 first
    halt_delay(d);
    chk(d == 4, "R1 R3 default slot 0 delay", d, 4);
    for (int v = 0; v < 10; v++) begin
      write_sel(VEC[v][10:8]);
      halt_delay(d);
      chk(d == int'(VEC[v][7:0]), $sformatf("R3 R4 vector %0d delay", v), d, VEC[v][7:0]);
      chk(start_addr_o == 11'h155, "R9 restart address kept", start_addr_o, 'h155);
    end

    // R5 select change during counting
    core_halt_i = 1'b1; tick; core_halt_i = 1'b0;
    chk(!running_o, "R3 not running while waiting", running_o, 0);
    write_sel(3'd2);
    d = 1;
    while (!restart_o && d < 200) begin tick; d++; end
    chk(d == 4, "R5 wait in progress unchanged", d, 4);
    halt_delay(d);
    chk(d == 8, "R5 new select at next halt", d, 8);

    // R8 wake
    wake_cmd_i = 1'b1; tick; wake_cmd_i = 1'b0;
    chk(wake_o && running_o && timer_en_o, "R8 wake pulse keeps run",
        {wake_o, running_o, timer_en_o}, 7);
    tick;
    chk(!wake_o, "R8 wake one cycle", wake_o, 0);
    halt_delay(d);
    chk(d == 8, "R8 restarts continue after wake", d, 8);

    // R6 end command
    end_cmd_i = 1'b1; tick; end_cmd_i = 1'b0;
    chk(!timer_en_o && running_o, "R6 end clears enable, run continues",
        {timer_en_o, running_o}, 1);
    core_halt_i = 1'b1; tick; core_halt_i = 1'b0;
    quiet_window(40, "R6 no restart after end");
    chk(!running_o, "R6 idle after halt", running_o, 0);

    // R7 relaunch
    do_launch(11'h02A);
    chk(timer_en_o && start_addr_o == 11'h02A, "R7 relaunch enables", timer_en_o, 1);
    halt_delay(d);
    chk(d == 8, "R7 restarts resume", d, 8);
    chk(start_addr_o == 11'h02A, "R9 new address kept", start_addr_o, 'h02A);

    // R6 end during counting cancels
    core_halt_i = 1'b1; tick; core_halt_i = 1'b0;
    tick;
    end_cmd_i = 1'b1; tick; end_cmd_i = 1'b0;
    quiet_window(40, "R6 end while waiting cancels");

    // R10 launch and end together
    launch_i = 1'b1; end_cmd_i = 1'b1; tick;
    launch_i = 1'b0; end_cmd_i = 1'b0;
    chk(timer_en_o && restart_o, "R10 launch wins over end", timer_en_o, 1);
    halt_delay(d);
    chk(d == 8, "R10 timer active after tie", d, 8);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule